// File: doc/BRIEF.md
# I2C Target Engine with Four Address Slots

This block is the target side of a two-wire serial bus. It samples SCL and SDA in the system clock domain and spots START and STOP conditions. After a START it shifts in the address byte. It compares bits 7:1 of that byte against four programmable slots. Slot 0 can also ignore chosen bit positions through a don't-care mask.

Each bus step that needs a decision becomes an event for software. There are three kinds: an address match, a received byte, and a request for a byte to send. An event raises a pending flag, sets a 2-bit event code, and holds SCL low until software answers. Software answers with a Continue pulse, which acknowledges and moves on, or a NACK pulse, which refuses. While sending, the engine keeps offering bytes for as long as the bus controller acknowledges them. A negative acknowledge ends the transfer, and the engine then waits for the next START or STOP.

The FSM states are:

| State | What the engine does |
|---|---|
| IDLE | Waits for a START. |
| ADDR | Shifts in the address byte. |
| RX | Shifts in a data byte. |
| WAIT | An event is pending and SCL is held low. |
| ACK | Drives the acknowledge bit low. |
| TX | Shifts a byte out, MSB first. |
| TXACK | Samples the bus controller's acknowledge. |
| SKIP | Bus released; waits for START or STOP. |

The transitions are:

- **To ADDR:** a START from any state.
- **To IDLE:** a STOP from any state.
- **ADDR to WAIT or SKIP:** on the eighth falling edge, WAIT on a hit and SKIP on a miss.
- **RX to WAIT:** on the eighth falling edge.
- **WAIT to ACK:** on Continue after an address or receive event.
- **WAIT to TX:** on Continue after a transmit event.
- **WAIT to SKIP:** on NACK.
- **ACK to WAIT or RX:** on the falling edge, WAIT with a transmit event for a read address, RX for a write address.
- **TX to TXACK:** after eight bits.
- **TXACK to WAIT or SKIP:** WAIT with a transmit event when acknowledged, SKIP when not.

Top module: `i2c_tgt_engine`

## Requirements
- R1: After reset the outputs are `pend_o`=0, `scl_oe_o`=0, `sda_oe_o`=0, `state_o`=0, `dat_o`=0x00 and `match_idx_o`=0.
- R2: Slot i occupies `slot_addr_i[8i+7:8i]`. Slot i matches when its bit 0 is 0 and its bits 7:1 equal address bits 7:1. When no slot matches, the engine raises no event and never drives SDA, so the bus controller reads a NAK.
- R3: A 1 in bit n (n=7..1) of `slot0_mask_i` makes address bit n always match for slot 0. The other slots compare every bit from 7 to 1.
- R4: When several slots match, `match_idx_o` gives the lowest matching index.
- R5: On a match, the engine sets `pend_o` with `state_o`=0, and `dat_o` holds the whole address byte including R/W in bit 0. Address 0x00 matches a slot programmed to 0x00 (general call).
- R6: `scl_oe_o` (SCL held low) is 1 exactly while `pend_o` is 1.
- R7: Continue on an address or data event drives SDA low for the acknowledge bit. A write transfer then produces an event with `state_o`=1 and the received byte in `dat_o`.
- R8: NACK leaves SDA released during the acknowledge bit and sends the engine to wait for START or STOP. NACK wins when Continue and NACK arrive in the same cycle.
- R9: After a read address (bit 0 = 1) is acknowledged, the engine raises an event with `state_o`=2. Continue then sends the data register MSB first. A data write in the same cycle as Continue supplies the byte that is sent.
- R10: An acknowledge from the bus controller after a sent byte raises another event with `state_o`=2. A NAK releases SDA and raises no further event until the next START.
- R11: A repeated START followed by a matching address during a transfer raises a new event with `state_o`=0.
- R12: Continue or NACK while `pend_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| slot_addr_i | input | 32 | Four address slots; bit 0 of each slot disables it |
| slot0_mask_i | input | 8 | Don't-care mask for slot 0 (bits 7:1) |
| ctl_cont_i | input | 1 | Continue pulse (acknowledge and proceed) |
| ctl_nack_i | input | 1 | NACK pulse (refuse) |
| dat_wr_i | input | 1 | Write strobe for the data register |
| dat_wdata_i | input | 8 | Byte to send |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low |
| pend_o | output | 1 | An event awaits a response |
| state_o | output | 2 | Event code: 0 address, 1 byte received, 2 ready to send, 3 reserved |
| dat_o | output | 8 | Address byte or received byte |
| match_idx_o | output | 2 | Index of the matched slot |

## Verification
Two pairs of actions can land in one clock cycle.

- **Data write with Continue:** in the ready-to-send state, the data-register write and the Continue pulse can coincide. The software model in the bench issues both in one cycle for one byte and on separate cycles for another. The byte that the bench's bus controller reads back must be the newly written value in both cases.
- **Continue with NACK:** the two response pulses can coincide on a received byte. This is judged by the acknowledge bit the bus controller samples, which must read as a NAK.

A per-cycle comparison confirms that the clock stretch tracks the pending flag throughout.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_WAIT,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        EV_ADDR    = 2'd0,
        EV_RXDATA  = 2'd1,
        EV_TXREADY = 2'd2,
        EV_RSVD    = 2'd3
    } tgt_event_e;

endpackage

// File: rtl/i2ct_bus_sync.sv
module i2ct_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Idle bus is high, so reset all stages to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_o      = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_q;
    assign scl_fall_o = ~scl_o & scl_q;
    // SDA moving while SCL stays high marks a START (falling) or STOP (rising)
    assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/i2ct_addr_match.sv
module i2ct_addr_match #(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    localparam int IDXW  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS*BYTE_W-1:0] slots_i,
    input  logic [BYTE_W-1:0]       mask_i,
    input  logic [BYTE_W-1:0]       addr_i,
    output logic                    hit_o,
    output logic [IDXW-1:0]         idx_o
);
    logic [SLOTS-1:0]  hit_vec;
    logic [BYTE_W-1:0] care [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Bit 0 (R/W) never takes part in the compare
        if (g == 0) begin : g_masked
            assign care[g] = ~(mask_i | BYTE_W'(1));
        end else begin : g_exact
            assign care[g] = ~BYTE_W'(1);
        end
        assign hit_vec[g] = ~slots_i[g*BYTE_W] &
            (((addr_i ^ slots_i[g*BYTE_W +: BYTE_W]) & care[g]) == '0);
    end

    // Lowest index wins
    always_comb begin
        hit_o = |hit_vec;
        idx_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx_o = IDXW'(i);
        end
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2ct_pkg::*;
#(
    parameter int SLOTS       = 4,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDXW       = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNTW       = $clog2(BYTE_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [SLOTS*BYTE_W-1:0] slot_addr_i,
    input  logic [BYTE_W-1:0]       slot0_mask_i,
    input  logic                    ctl_cont_i,
    input  logic                    ctl_nack_i,
    input  logic                    dat_wr_i,
    input  logic [BYTE_W-1:0]       dat_wdata_i,
    output logic                    scl_oe_o,
    output logic                    sda_oe_o,
    output logic                    pend_o,
    output logic [1:0]              state_o,
    output logic [BYTE_W-1:0]       dat_o,
    output logic [IDXW-1:0]         match_idx_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic hit;
    logic [IDXW-1:0] hit_idx;

    tgt_state_e        state_q, state_d;
    tgt_event_e        code_q, code_d;
    logic [CNTW-1:0]   cnt_q, cnt_d;
    logic [BYTE_W-1:0] shift_q, shift_d;
    logic [BYTE_W-1:0] dat_q, dat_d;
    logic [IDXW-1:0]   idx_q, idx_d;
    logic              pend_q, pend_d;
    logic              rd_q, rd_d;
    logic              mack_q, mack_d;
    logic              resp;

    i2ct_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2ct_addr_match #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_match (
        .slots_i (slot_addr_i),
        .mask_i  (slot0_mask_i),
        .addr_i  (shift_q),
        .hit_o   (hit),
        .idx_o   (hit_idx)
    );

    // Only a pending event accepts a response
    assign resp = pend_q & (ctl_cont_i | ctl_nack_i);

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        cnt_d   = cnt_q;
        shift_d = shift_q;
        dat_d   = dat_q;
        idx_d   = idx_q;
        pend_d  = pend_q;
        rd_d    = rd_q;
        mack_d  = mack_q;
        if (dat_wr_i) dat_d = dat_wdata_i;

        if (bus_stop) begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
        end else if (bus_start) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
            pend_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shift_d = {shift_q[BYTE_W-2:0], sda_s};
                        cnt_d   = cnt_q + CNTW'(1);
                    end else if (scl_fall && cnt_q == CNTW'(BYTE_W)) begin
                        if (hit) begin
                            state_d = ST_WAIT;
                            pend_d  = 1'b1;
                            code_d  = EV_ADDR;
                            dat_d   = shift_q;
                            idx_d   = hit_idx;
                            rd_d    = shift_q[0];
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        shift_d = {shift_q[BYTE_W-2:0], sda_s};
                        cnt_d   = cnt_q + CNTW'(1);
                    end else if (scl_fall && cnt_q == CNTW'(BYTE_W)) begin
                        state_d = ST_WAIT;
                        pend_d  = 1'b1;
                        code_d  = EV_RXDATA;
                        dat_d   = shift_q;
                    end
                end
                ST_WAIT: begin
                    if (resp) begin
                        pend_d = 1'b0;
                        if (ctl_nack_i) begin
                            state_d = ST_SKIP;
                        end else if (code_q == EV_TXREADY) begin
                            state_d = ST_TX;
                            cnt_d   = '0;
                            shift_d = dat_wr_i ? dat_wdata_i : dat_q;
                        end else begin
                            state_d = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (rd_q) begin
                            state_d = ST_WAIT;
                            pend_d  = 1'b1;
                            code_d  = EV_TXREADY;
                        end else begin
                            state_d = ST_RX;
                            cnt_d   = '0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == CNTW'(BYTE_W - 1)) begin
                            state_d = ST_TXACK;
                        end else begin
                            shift_d = {shift_q[BYTE_W-2:0], 1'b0};
                            cnt_d   = cnt_q + CNTW'(1);
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_d = ST_WAIT;
                            pend_d  = 1'b1;
                            code_d  = EV_TXREADY;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= EV_ADDR;
            cnt_q   <= '0;
            shift_q <= '0;
            dat_q   <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            rd_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
            dat_q   <= dat_d;
            idx_q   <= idx_d;
            pend_q  <= pend_d;
            rd_q    <= rd_d;
            mack_q  <= mack_d;
        end
    end

    // Output decode
    always_comb begin
        scl_oe_o    = (state_q == ST_WAIT);
        sda_oe_o    = (state_q == ST_ACK) | ((state_q == ST_TX) & ~shift_q[BYTE_W-1]);
        pend_o      = pend_q;
        state_o     = code_q;
        dat_o       = dat_q;
        match_idx_o = idx_q;
    end

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    localparam int IDXW  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [SLOTS*BYTE_W-1:0] slot_addr_i,
    input logic [BYTE_W-1:0]       slot0_mask_i,
    input logic                    ctl_cont_i,
    input logic                    ctl_nack_i,
    input logic                    scl_oe_o,
    input logic                    sda_oe_o,
    input logic                    pend_o,
    input logic [1:0]              state_o,
    input logic [BYTE_W-1:0]       dat_o,
    input logic [IDXW-1:0]         match_idx_o
);
    logic [BYTE_W-1:0] sel_slot;
    logic [BYTE_W-1:0] sel_care;

    assign sel_slot = slot_addr_i[int'(match_idx_o)*BYTE_W +: BYTE_W];
    assign sel_care = (match_idx_o == '0) ? ~(slot0_mask_i | BYTE_W'(1)) : ~BYTE_W'(1);

    // R6
    pend_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> scl_oe_o);

    // R6
    scl_only_when_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> pend_o);

    // R7
    resp_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o && (ctl_cont_i || ctl_nack_i) |=> !pend_o);

    // R2
    matched_slot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) && state_o == 2'd0 |->
            !sel_slot[0] && (((dat_o ^ sel_slot) & sel_care) == '0));

    // R8
    nack_releases_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o && ctl_nack_i && state_o != 2'd2 |=> !sda_oe_o);

    // R5
    event_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o && $past(pend_o) |-> $stable(state_o) && $stable(match_idx_o));

    // R9
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'd3);

endmodule

bind i2c_tgt_engine i2ct_checker #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_addr_i  (slot_addr_i),
    .slot0_mask_i (slot0_mask_i),
    .ctl_cont_i   (ctl_cont_i),
    .ctl_nack_i   (ctl_nack_i),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .pend_o       (pend_o),
    .state_o      (state_o),
    .dat_o        (dat_o),
    .match_idx_o  (match_idx_o)
);

// File: tb/i2c_tgt_engine_tb.sv
module i2c_tgt_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 8;   // clocks per half bit

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        scl_line, sda_line;
    logic [31:0] slots = {8'hA0, 8'hA0, 8'h00, 8'h50};
    logic [7:0]  mask = 8'h06;
    logic        cont = 1'b0, nack = 1'b0, dwr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        scl_oe, sda_oe, pend;
    logic [1:0]  st;
    logic [7:0]  dat;
    logic [1:0]  idx;

    int checks = 0;
    int fails  = 0;
    int events = 0;

    typedef struct {
        int st; int dat; int idx; int reply; int tx; bit same;
    } ev_t;
    ev_t evq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_tgt_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .slot_addr_i  (slots),
        .slot0_mask_i (mask),
        .ctl_cont_i   (cont),
        .ctl_nack_i   (nack),
        .dat_wr_i     (dwr),
        .dat_wdata_i  (wdata),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .pend_o       (pend),
        .state_o      (st),
        .dat_o        (dat),
        .match_idx_o  (idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; hw(HB);
        sda_m = 1'b0; hw(HB);
        scl_m = 1'b0; hw(HB);
    endtask

    task automatic m_restart();
        sda_m = 1'b1; hw(HB);
        scl_m = 1'b1; wait_high(); hw(HB);
        sda_m = 1'b0; hw(HB);
        scl_m = 1'b0; hw(HB);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hw(HB);
        scl_m = 1'b1; wait_high(); hw(HB);
        sda_m = 1'b1; hw(HB);
    endtask

    task automatic m_bit_out(input logic b);
        sda_m = b; hw(HB);
        scl_m = 1'b1; wait_high(); hw(HB);
        scl_m = 1'b0; hw(HB);
    endtask

    task automatic m_bit_in(output logic b);
        sda_m = 1'b1; hw(HB);
        scl_m = 1'b1; wait_high(); hw(HB/2);
        b = sda_line; hw(HB/2);
        scl_m = 1'b0; hw(HB);
    endtask

    task automatic m_byte_out(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
        m_bit_in(a);
        acked = ~a;
    endtask

    task automatic m_byte_in(output logic [7:0] v, input logic nak);
        for (int i = 7; i >= 0; i--) m_bit_in(v[i]);
        m_bit_out(nak);
    endtask

    function automatic ev_t mk(input int s, input int d, input int ix, input int rep,
                               input int tx, input bit same);
        ev_t e;
        e.st = s; e.dat = d; e.idx = ix; e.reply = rep; e.tx = tx; e.same = same;
        return e;
    endfunction

    // Per-clock comparison of the stretch against the pending flag
    always @(negedge clk) begin
        if (rst_n) check(scl_oe == pend, "R6 stretch tracks pending", scl_oe, pend);
    end

    // Software model: answers each event from the expectation queue
    initial begin
        ev_t e;
        forever begin
            @(negedge clk);
            if (rst_n && pend) begin
                events++;
                if (evq.size() == 0) begin
                    check(1'b0, "R2 unexpected event", st, 9);
                    nack = 1'b1; @(negedge clk); nack = 1'b0;
                end else begin
                    e = evq.pop_front();
                    check(st == e.st[1:0], "R5/R7/R9 event code", st, e.st);
                    if (e.st == 0) begin
                        check(dat == e.dat[7:0], "R5 address byte", dat, e.dat);
                        check(idx == e.idx[1:0], "R4 match index", idx, e.idx);
                    end else if (e.st == 1) begin
                        check(dat == e.dat[7:0], "R7 received byte", dat, e.dat);
                    end
                    hw(4);
                    check(scl_line == 1'b0, "R6 SCL held low while pending", scl_line, 0);
                    if (e.st == 2 && !e.same) begin
                        dwr = 1'b1; wdata = e.tx[7:0]; @(negedge clk);
                        dwr = 1'b0; wdata = 8'h00; @(negedge clk);
                    end
                    if (e.st == 2 && e.same) begin
                        dwr = 1'b1; wdata = e.tx[7:0];
                    end
                    cont = (e.reply == 0 || e.reply == 2);
                    nack = (e.reply == 1 || e.reply == 2);
                    @(negedge clk);
                    cont = 1'b0; nack = 1'b0; dwr = 1'b0; wdata = 8'h00;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        bit         ack;
        logic [7:0] rb;
        int         ev0;

        hw(5);
        // R1 reset state
        check(pend == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R1 reset outputs",
              {pend, scl_oe, sda_oe}, 0);
        check(st == 2'd0 && dat == 8'h00 && idx == 2'd0, "R1 reset registers",
              {st, dat, idx}, 0);
        rst_n = 1'b1;
        hw(5);

        // R4: slots 2 and 3 both hold 0xA0, lowest wins; software refuses (R8)
        evq.push_back(mk(0, 8'hA0, 2, 1, 0, 0));
        m_start(); m_byte_out(8'hA0, ack); m_stop();
        check(ack == 1'b0, "R8 address refused reads NAK", ack, 0);
        check(evq.size() == 0, "R4 event at slot 2 consumed", evq.size(), 0);

        // R2: slot 2 disabled by bit 0, slot 3 now wins
        slots[23:16] = 8'hA1;
        evq.push_back(mk(0, 8'hA0, 3, 0, 0, 0));
        m_start(); m_byte_out(8'hA0, ack); m_stop();
        check(ack == 1'b1, "R7 address acknowledged", ack, 1);

        // R2: both disabled, no event and NAK
        slots[31:24] = 8'hA1;
        ev0 = events;
        m_start(); m_byte_out(8'hA0, ack); m_stop();
        check(ack == 1'b0, "R2 no match reads NAK", ack, 0);
        check(events == ev0, "R2 no event on miss", events, ev0);

        // R3: mask covers bits 2:1 of slot 0
        evq.push_back(mk(0, 8'h56, 0, 0, 0, 0));
        m_start(); m_byte_out(8'h56, ack); m_stop();
        check(ack == 1'b1, "R3 masked bits match", ack, 1);
        ev0 = events;
        m_start(); m_byte_out(8'h58, ack); m_stop();
        check(ack == 1'b0 && events == ev0, "R3 unmasked bit differs", ack, 0);

        // R5: general call
        evq.push_back(mk(0, 8'h00, 1, 0, 0, 0));
        m_start(); m_byte_out(8'h00, ack); m_stop();
        check(ack == 1'b1, "R5 general call acknowledged", ack, 1);

        // R7/R8: write transfer, last byte refused
        evq.push_back(mk(0, 8'h50, 0, 0, 0, 0));
        evq.push_back(mk(1, 8'h3C, 0, 0, 0, 0));
        evq.push_back(mk(1, 8'hC3, 0, 0, 0, 0));
        evq.push_back(mk(1, 8'h99, 0, 1, 0, 0));
        m_start(); m_byte_out(8'h50, ack);
        m_byte_out(8'h3C, ack); check(ack == 1'b1, "R7 data byte 1 ACK", ack, 1);
        m_byte_out(8'hC3, ack); check(ack == 1'b1, "R7 data byte 2 ACK", ack, 1);
        m_byte_out(8'h99, ack); check(ack == 1'b0, "R8 data byte refused", ack, 0);
        m_stop();

        // R9/R10: read transfer, second byte written in the same cycle as Continue
        evq.push_back(mk(0, 8'h51, 0, 0, 0, 0));
        evq.push_back(mk(2, 0, 0, 0, 8'hA5, 0));
        evq.push_back(mk(2, 0, 0, 0, 8'h5A, 1));
        m_start(); m_byte_out(8'h51, ack);
        check(ack == 1'b1, "R9 read address ACK", ack, 1);
        m_byte_in(rb, 1'b0); check(rb == 8'hA5, "R9 sent byte", rb, 8'hA5);
        m_byte_in(rb, 1'b1); check(rb == 8'h5A, "R9 same-cycle write sent", rb, 8'h5A);
        check(sda_oe == 1'b0, "R10 SDA released after NAK", sda_oe, 0);
        m_stop();
        check(evq.size() == 0, "R10 no event after NAK", evq.size(), 0);

        // R11: repeated START
        evq.push_back(mk(0, 8'h50, 0, 0, 0, 0));
        evq.push_back(mk(1, 8'h11, 0, 0, 0, 0));
        evq.push_back(mk(0, 8'h51, 0, 0, 0, 0));
        evq.push_back(mk(2, 0, 0, 0, 8'h77, 0));
        m_start(); m_byte_out(8'h50, ack); m_byte_out(8'h11, ack);
        m_restart(); m_byte_out(8'h51, ack);
        check(ack == 1'b1, "R11 address after repeated START", ack, 1);
        m_byte_in(rb, 1'b1); check(rb == 8'h77, "R11 read after repeated START", rb, 8'h77);
        m_stop();
        check(evq.size() == 0, "R11 all events seen", evq.size(), 0);

        // R12: responses with nothing pending
        @(negedge clk); cont = 1'b1; @(negedge clk); cont = 1'b0; nack = 1'b1;
        @(negedge clk); nack = 1'b0; @(negedge clk);
        check(pend == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R12 idle response ignored",
              {pend, scl_oe, sda_oe}, 0);
        evq.push_back(mk(0, 8'h50, 0, 0, 0, 0));
        m_start(); m_byte_out(8'h50, ack); m_stop();
        check(ack == 1'b1, "R12 next transfer unaffected", ack, 1);

        // R8: Continue and NACK in one cycle, NACK wins
        evq.push_back(mk(0, 8'h50, 0, 0, 0, 0));
        evq.push_back(mk(1, 8'hE7, 0, 2, 0, 0));
        m_start(); m_byte_out(8'h50, ack); m_byte_out(8'hE7, ack);
        check(ack == 1'b0, "R8 NACK wins over Continue", ack, 0);
        m_stop();

        hw(20);
        check(evq.size() == 0, "R5 expectation queue drained", evq.size(), 0);
        finish_run();
    end

endmodule